// File: doc/BRIEF.md
# PHY Management Register Model

This block models the register file of an Ethernet PHY as seen through a controller's management frame register. Software writes one 32-bit frame word. The word holds a direction bit, a flat PHY/register address and 16 data bits. The block decodes the word, carries out the access against its internal registers in the same clock, and raises a management-done flag. No serial pin timing is modelled. Every access completes on the clock edge that accepts the frame.

The internal registers are control, status, advertisement, interrupt source and interrupt mask. The link-partner ability and expansion registers return constants. A `link_up` input is tracked, and each change of level updates the status link bits and sets interrupt-source bits. Autonegotiation finishes the moment it is requested. A soft reset through the control register restores every reset value.

Top module: `mgmt_phy_model`

## Requirements
- R1: After a synchronous reset with `link_up` low, the frame register and done flag read 0. Status reads 0x7809, control 0x3000, advertisement 0x01E1, and interrupt source and mask read 0.
- R2: Frame address bits 27:23 select the PHY and bits 22:18 select the register (flat address / 32 and flat address mod 32). When the PHY number differs from `PHY_ADDR`, a read returns 0 and a write changes nothing.
- R3: Frame bit 29 = 1 means read and 0 means write; bits 15:0 carry data. A write leaves the frame register equal to the written word. A read leaves bits 31:16 as written and places the register value in bits 15:0. Both take effect on the accepting clock edge.
- R4: Every accepted frame, whatever its address, sets `mgmt_done` on that edge. `done_clr` clears it, and a new frame in the same cycle wins over the clear.
- R5: A write to register 0 without bit 15 stores the value ANDed with 0x7980.
- R6: A register-0 write with bit 12 set also sets status bit 5 (autonegotiation complete) on the same edge.
- R7: A write to register 4 stores (value AND 0x2D7F) OR 0x0080.
- R8: A write to register 30 (interrupt mask) keeps only bits 7:0.
- R9: A falling `link_up` clears status bits 5 and 2 and sets interrupt-source bit 4 on the next edge. This takes priority over an autonegotiation request on that edge.
- R10: A rising `link_up` sets status bits 5 and 2 and interrupt-source bits 7 and 6 on the next edge.
- R11: A read of register 29 returns the interrupt source and clears it. A link event on the same edge leaves its bits set for the next read.
- R12: A register-0 write with bit 15 set restores all R1 register values and forgets the tracked link level. If `link_up` is high, the R10 event then follows on the next edge.
- R13: Register 5 reads `LP_ABILITY` and register 6 reads `AN_EXPANSION`. Every other unlisted register reads 0, and writes to registers other than 0, 4 and 30 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_we | input | 1 | Write strobe for the management frame register; starts one access |
| frame_wdata | input | 32 | Management frame word |
| done_clr | input | 1 | Clears the management-done flag |
| link_up | input | 1 | Current link level |
| frame_rdata | output | 32 | Management frame register contents |
| mgmt_done | output | 1 | Management-done event flag |

## Verification
The assertions assume that `link_up` is a clean level, already synchronous to `clk`, and that it changes at most once per cycle. They also assume that `frame_we` and `done_clr` are single-cycle strobes. The bench drives every input at the falling edge and changes `link_up` only between accesses, except in the deliberate case where a link change and an interrupt-source read share one edge. Several other corner cases are driven on purpose:
- a frame and `done_clr` in the same cycle;
- a soft reset while the link is up;
- accesses to a foreign PHY number.

// File: rtl/mgmt_phy_pkg.sv
// Package: shared constants and the decoded-access type for the PHY
// management register model. Assumes the 32-bit frame layout is fixed.
package mgmt_phy_pkg;

    localparam int FRAME_W   = 32;
    localparam int DATA_W    = 16;
    localparam int PHY_W     = 5;
    localparam int REG_W     = 5;
    localparam int ADDR_W    = PHY_W + REG_W;
    localparam int EVT_W     = 8;

    // frame word field positions
    localparam int FR_RD_BIT = 29;
    localparam int FR_ADDR_LO = 18;
    localparam int FR_ADDR_HI = FR_ADDR_LO + ADDR_W - 1;

    // register numbers
    localparam logic [REG_W-1:0] R_CTRL  = 5'd0;
    localparam logic [REG_W-1:0] R_STAT  = 5'd1;
    localparam logic [REG_W-1:0] R_ADV   = 5'd4;
    localparam logic [REG_W-1:0] R_LPA   = 5'd5;
    localparam logic [REG_W-1:0] R_EXP   = 5'd6;
    localparam logic [REG_W-1:0] R_ISRC  = 5'd29;
    localparam logic [REG_W-1:0] R_IMASK = 5'd30;

    // reset values
    localparam logic [DATA_W-1:0] CTRL_RST = 16'h3000;
    localparam logic [DATA_W-1:0] STAT_RST = 16'h7809;
    localparam logic [DATA_W-1:0] ADV_RST  = 16'h01E1;

    // write masks and fixed bits
    localparam logic [DATA_W-1:0] CTRL_WMASK = 16'h7980;
    localparam logic [DATA_W-1:0] ADV_WMASK  = 16'h2D7F;
    localparam logic [DATA_W-1:0] ADV_FORCE  = 16'h0080;

    localparam int CTRL_SOFTRST_BIT = 15;
    localparam int CTRL_ANREQ_BIT   = 12;

    // status bits touched by link / autoneg
    localparam logic [DATA_W-1:0] STAT_ANDONE = 16'h0020;
    localparam logic [DATA_W-1:0] STAT_LINK   = 16'h0024;

    // interrupt-source bits
    localparam logic [EVT_W-1:0] EVT_DOWN = 8'h10;
    localparam logic [EVT_W-1:0] EVT_UP   = 8'hC0;

    typedef struct packed {
        logic              rd;
        logic              hit;
        logic [REG_W-1:0]  regno;
        logic [DATA_W-1:0] data;
    } mgmt_op_t;

endpackage

// File: rtl/mgmt_frame_decode.sv
// Module: splits the frame fields into a decoded access.
// Assumes the caller slices the direction bit, flat address and data out of
// the frame word. Purely combinational.
module mgmt_frame_decode
    import mgmt_phy_pkg::*;
#(
    parameter logic [PHY_W-1:0] PHY_ADDR = 5'd1
) (
    input  logic              rd_bit,
    input  logic [ADDR_W-1:0] flat_addr,
    input  logic [DATA_W-1:0] data,
    output mgmt_op_t          op
);

    // field split: upper bits are the PHY number, lower bits the register
    always_comb begin
        op.rd    = rd_bit;
        op.hit   = (flat_addr[ADDR_W-1:REG_W] == PHY_ADDR);
        op.regno = flat_addr[REG_W-1:0];
        op.data  = data;
    end

endmodule

// File: rtl/mgmt_link_tracker.sv
// Module: remembers the last seen link level and reports its edges.
// Assumes link_up is already synchronous to clk. A restart forgets the
// level, so a high link is reported as a rise again on the next cycle.
module mgmt_link_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic link_up,
    output logic rise,
    output logic fall
);

    logic level_q;

    // edge detection against the stored level
    always_comb begin
        rise = link_up & ~level_q;
        fall = ~link_up & level_q;
    end

    // stored level, cleared by reset or restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart) level_q <= 1'b0;
        else                   level_q <= link_up;
    end

    // a reported rise is not reported again unless the level is forgotten
    p_single_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rise && !restart |=> !rise);

    // a reported fall is not followed by a second fall
    p_single_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fall && !restart |=> !fall);

endmodule

// File: rtl/mgmt_phy_regs.sv
// Module: PHY register file with masked writes, clear-on-read interrupt
// source, link event updates and soft reset. Assumes rd_en and wr_en are
// never high together and are only high for an access to this PHY.
module mgmt_phy_regs
    import mgmt_phy_pkg::*;
#(
    parameter logic [DATA_W-1:0] LP_ABILITY   = 16'h05E1,
    parameter logic [DATA_W-1:0] AN_EXPANSION = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  regno,
    input  logic [DATA_W-1:0] wdata,
    input  logic              link_rise,
    input  logic              link_fall,
    output logic [DATA_W-1:0] rdata,
    output logic              soft_rst
);

    logic [DATA_W-1:0] ctrl_q, ctrl_d;
    logic [DATA_W-1:0] stat_q, stat_d;
    logic [DATA_W-1:0] adv_q,  adv_d;
    logic [EVT_W-1:0]  isrc_q, isrc_d;
    logic [EVT_W-1:0]  imask_q, imask_d;

    // soft reset request decoded from a control write
    always_comb soft_rst = wr_en && (regno == R_CTRL) && wdata[CTRL_SOFTRST_BIT];

    // read multiplexer
    always_comb begin
        case (regno)
            R_CTRL:  rdata = ctrl_q;
            R_STAT:  rdata = stat_q;
            R_ADV:   rdata = adv_q;
            R_LPA:   rdata = LP_ABILITY;
            R_EXP:   rdata = AN_EXPANSION;
            R_ISRC:  rdata = {{(DATA_W-EVT_W){1'b0}}, isrc_q};
            R_IMASK: rdata = {{(DATA_W-EVT_W){1'b0}}, imask_q};
            default: rdata = '0;
        endcase
    end

    // next state: access effects first, link events last so they win
    always_comb begin
        ctrl_d  = ctrl_q;
        stat_d  = stat_q;
        adv_d   = adv_q;
        isrc_d  = isrc_q;
        imask_d = imask_q;
        if (soft_rst) begin
            ctrl_d  = CTRL_RST;
            stat_d  = STAT_RST;
            adv_d   = ADV_RST;
            isrc_d  = '0;
            imask_d = '0;
        end else if (wr_en) begin
            case (regno)
                R_CTRL: begin
                    ctrl_d = wdata & CTRL_WMASK;
                    if (wdata[CTRL_ANREQ_BIT]) stat_d = stat_q | STAT_ANDONE;
                end
                R_ADV:   adv_d   = (wdata & ADV_WMASK) | ADV_FORCE;
                R_IMASK: imask_d = wdata[EVT_W-1:0];
                default: ;
            endcase
        end
        if (rd_en && (regno == R_ISRC)) isrc_d = '0;
        if (link_fall) begin
            stat_d = stat_d & ~STAT_LINK;
            isrc_d = isrc_d | EVT_DOWN;
        end
        if (link_rise) begin
            stat_d = stat_d | STAT_LINK;
            isrc_d = isrc_d | EVT_UP;
        end
    end

    // register state with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RST;
            stat_q  <= STAT_RST;
            adv_q   <= ADV_RST;
            isrc_q  <= '0;
            imask_q <= '0;
        end else begin
            ctrl_q  <= ctrl_d;
            stat_q  <= stat_d;
            adv_q   <= adv_d;
            isrc_q  <= isrc_d;
            imask_q <= imask_d;
        end
    end

    // control changes only through a control write
    p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && regno == R_CTRL) |=> $stable(ctrl_q));

    // advertisement changes only through its own write or a soft reset
    p_adv_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && regno == R_ADV) && !soft_rst |=> $stable(adv_q));

    // mask changes only through its own write or a soft reset
    p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && regno == R_IMASK) && !soft_rst |=> $stable(imask_q));

    // a falling link leaves link and autoneg status clear
    p_fall_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_fall |=> (stat_q & STAT_LINK) == '0);

    // a rising link leaves both up-event bits set
    p_rise_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        link_rise |=> isrc_q[7:6] == 2'b11);

    // reading the source with no concurrent event empties it
    p_src_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && regno == R_ISRC && !link_rise && !link_fall |=> isrc_q == '0);

    // a soft reset brings control back to its reset value
    p_soft_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> ctrl_q == CTRL_RST);

endmodule

// File: rtl/mgmt_phy_model.sv
// Module: top of the PHY management model. Holds the frame register and the
// done flag, decodes each frame and drives the register file.
// Assumes frame_we and done_clr are single-cycle strobes; each access
// completes on the edge that accepts it.
module mgmt_phy_model
    import mgmt_phy_pkg::*;
#(
    parameter logic [PHY_W-1:0]  PHY_ADDR     = 5'd1,
    parameter logic [DATA_W-1:0] LP_ABILITY   = 16'h05E1,
    parameter logic [DATA_W-1:0] AN_EXPANSION = 16'h0001
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_we,
    input  logic [FRAME_W-1:0] frame_wdata,
    input  logic               done_clr,
    input  logic               link_up,
    output logic [FRAME_W-1:0] frame_rdata,
    output logic               mgmt_done
);

    mgmt_op_t          op;
    logic [DATA_W-1:0] reg_rdata;
    logic [DATA_W-1:0] rd_value;
    logic              soft_rst;
    logic              link_rise;
    logic              link_fall;
    logic              rd_en;
    logic              wr_en;
    logic [FRAME_W-1:0] frame_q;
    logic              done_q;

    mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_decode (
        .rd_bit    (frame_wdata[FR_RD_BIT]),
        .flat_addr (frame_wdata[FR_ADDR_HI:FR_ADDR_LO]),
        .data      (frame_wdata[DATA_W-1:0]),
        .op        (op)
    );

    // access enables for the addressed PHY only
    always_comb begin
        rd_en = frame_we && op.hit && op.rd;
        wr_en = frame_we && op.hit && !op.rd;
    end

    mgmt_link_tracker u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (soft_rst),
        .link_up (link_up),
        .rise    (link_rise),
        .fall    (link_fall)
    );

    mgmt_phy_regs #(
        .LP_ABILITY   (LP_ABILITY),
        .AN_EXPANSION (AN_EXPANSION)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .regno     (op.regno),
        .wdata     (op.data),
        .link_rise (link_rise),
        .link_fall (link_fall),
        .rdata     (reg_rdata),
        .soft_rst  (soft_rst)
    );

    // a foreign PHY reads as zero
    always_comb rd_value = op.hit ? reg_rdata : '0;

    // frame register: writes store the word, reads deposit the result
    always_ff @(posedge clk) begin
        if (!rst_n)        frame_q <= '0;
        else if (frame_we) frame_q <= op.rd ? {frame_wdata[FRAME_W-1:DATA_W], rd_value}
                                            : frame_wdata;
    end

    // done flag: set by any access, cleared by request, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (frame_we) done_q <= 1'b1;
        else if (done_clr) done_q <= 1'b0;
    end

    always_comb begin
        frame_rdata = frame_q;
        mgmt_done   = done_q;
    end

    // every access raises the done flag
    p_done_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_we |=> done_q);

    // a write frame is held verbatim
    p_frame_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        frame_we && !frame_wdata[FR_RD_BIT] |=> frame_q == $past(frame_wdata));

    // a foreign read returns zero data
    p_foreign_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_we && frame_wdata[FR_RD_BIT] && !op.hit |=> frame_q[DATA_W-1:0] == '0);

endmodule

// File: tb/mgmt_phy_model_tb.sv
module mgmt_phy_model_tb;

    localparam int MY_PHY = 1;
    localparam int OTHER_PHY = 0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_we = 1'b0;
    logic [31:0] frame_wdata = '0;
    logic        done_clr = 1'b0;
    logic        link_up = 1'b0;
    logic [31:0] frame_rdata;
    logic        mgmt_done;

    int n_checks = 0;
    int n_errors = 0;
    string cur_req = "R1";

    mgmt_phy_model u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_we    (frame_we),
        .frame_wdata (frame_wdata),
        .done_clr    (done_clr),
        .link_up     (link_up),
        .frame_rdata (frame_rdata),
        .mgmt_done   (mgmt_done)
    );

    always #5 clk = ~clk;

    // behavioural reference state
    logic [15:0] m_ctrl, m_stat, m_adv;
    logic [7:0]  m_src, m_mask;
    logic        m_link, m_done, m_valid;
    logic [31:0] m_frame;
    initial m_valid = 1'b0;

    function automatic logic [15:0] m_read(input int r);
        case (r)
            0: return m_ctrl;
            1: return m_stat;
            4: return m_adv;
            5: return 16'h05E1;
            6: return 16'h0001;
            29: return {8'h00, m_src};
            30: return {8'h00, m_mask};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic m_reset();
        m_ctrl = 16'h3000; m_stat = 16'h7809; m_adv = 16'h01E1;
        m_src = 0; m_mask = 0;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_reset();
            m_link = 0; m_frame = 0; m_done = 0; m_valid = 1'b1;
        end else begin
            logic rise, fall, nl;
            rise = link_up && !m_link;
            fall = !link_up && m_link;
            nl = link_up;
            if (done_clr) m_done = 0;
            if (frame_we) begin
                int phy, r;
                logic [15:0] d;
                phy = int'(frame_wdata[27:23]);
                r = int'(frame_wdata[22:18]);
                d = frame_wdata[15:0];
                m_done = 1;
                if (frame_wdata[29]) begin
                    m_frame = {frame_wdata[31:16], (phy == MY_PHY) ? m_read(r) : 16'h0};
                    if (phy == MY_PHY && r == 29) m_src = 0;
                end else begin
                    m_frame = frame_wdata;
                    if (phy == MY_PHY) begin
                        if (r == 0 && d[15]) begin
                            m_reset(); nl = 0;
                        end else if (r == 0) begin
                            m_ctrl = d & 16'h7980;
                            if (d[12]) m_stat = m_stat | 16'h0020;
                        end else if (r == 4) m_adv = (d & 16'h2D7F) | 16'h0080;
                        else if (r == 30) m_mask = d[7:0];
                    end
                end
            end
            if (fall) begin m_stat = m_stat & ~16'h0024; m_src = m_src | 8'h10; end
            if (rise) begin m_stat = m_stat | 16'h0024; m_src = m_src | 8'hC0; end
            m_link = nl;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the reference at every falling edge
    always @(negedge clk) begin
        if (m_valid && rst_n) begin
            chk({cur_req, " R3 frame model"}, frame_rdata, m_frame);
            chk({cur_req, " R4 done model"}, {31'd0, mgmt_done}, {31'd0, m_done});
        end
    end

    function automatic logic [31:0] frame(input logic rd, input int phy, input int r,
                                          input logic [15:0] d);
        logic [9:0] a;
        a = 10'(phy * 32 + r);
        return {2'b01, rd, 1'b0, a, 2'b00, d};
    endfunction

    task automatic op(input logic [31:0] w);
        @(negedge clk);
        frame_we = 1'b1; frame_wdata = w;
        @(negedge clk);
        frame_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int phy, input int r, input logic [15:0] exp);
        op(frame(1'b1, phy, r, 16'hBEEF));
        chk(req, {16'h0, frame_rdata[15:0]}, {16'h0, exp});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 frame", frame_rdata, 32'h0);
        chk("R1 done", {31'd0, mgmt_done}, 32'd0);
        rd_chk("R1 status", MY_PHY, 1, 16'h7809);
        rd_chk("R1 control", MY_PHY, 0, 16'h3000);
        rd_chk("R1 adv", MY_PHY, 4, 16'h01E1);
        rd_chk("R1 isrc", MY_PHY, 29, 16'h0000);
        rd_chk("R1 imask", MY_PHY, 30, 16'h0000);

        // R4 done flag
        cur_req = "R4";
        chk("R4 done after access", {31'd0, mgmt_done}, 32'd1);
        @(negedge clk); done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        chk("R4 done cleared", {31'd0, mgmt_done}, 32'd0);
        @(negedge clk); done_clr = 1'b1; frame_we = 1'b1;
        frame_wdata = frame(1'b1, MY_PHY, 1, 16'h0);
        @(negedge clk); done_clr = 1'b0; frame_we = 1'b0;
        chk("R4 set wins over clear", {31'd0, mgmt_done}, 32'd1);

        // R3 frame layout
        cur_req = "R3";
        op(frame(1'b0, MY_PHY, 2, 16'h1234));
        chk("R3 write frame kept", frame_rdata, frame(1'b0, MY_PHY, 2, 16'h1234));
        op(frame(1'b1, MY_PHY, 0, 16'hFFFF));
        chk("R3 read upper half", {16'h0, frame_rdata[31:16]}, {16'h0, frame(1'b1, MY_PHY, 0, 16'h0) >> 16});

        // R5 / R6 control writes
        cur_req = "R5";
        op(frame(1'b0, MY_PHY, 0, 16'h7FFF));
        rd_chk("R5 control mask", MY_PHY, 0, 16'h7980);
        rd_chk("R6 autoneg done", MY_PHY, 1, 16'h7829);
        op(frame(1'b0, MY_PHY, 0, 16'h0100));
        rd_chk("R5 control plain", MY_PHY, 0, 16'h0100);

        // R7 advertisement
        cur_req = "R7";
        op(frame(1'b0, MY_PHY, 4, 16'hFFFF));
        rd_chk("R7 adv all ones", MY_PHY, 4, 16'h2DFF);
        op(frame(1'b0, MY_PHY, 4, 16'h0000));
        rd_chk("R7 adv zero", MY_PHY, 4, 16'h0080);

        // R8 mask
        cur_req = "R8";
        op(frame(1'b0, MY_PHY, 30, 16'hABCD));
        rd_chk("R8 mask low byte", MY_PHY, 30, 16'h00CD);

        // R2 foreign PHY
        cur_req = "R2";
        rd_chk("R2 foreign read zero", OTHER_PHY, 30, 16'h0000);
        op(frame(1'b0, OTHER_PHY, 30, 16'h0055));
        rd_chk("R2 foreign write ignored", MY_PHY, 30, 16'h00CD);

        // R10 link up, R11 read clear
        cur_req = "R10";
        link_up = 1'b1; idle(2);
        rd_chk("R10 status link up", MY_PHY, 1, 16'h782D);
        rd_chk("R10 isrc up bits", MY_PHY, 29, 16'h00C0);
        rd_chk("R11 isrc cleared", MY_PHY, 29, 16'h0000);

        // R9 link down
        cur_req = "R9";
        link_up = 1'b0; idle(2);
        rd_chk("R9 status link down", MY_PHY, 1, 16'h7809);

        // R11 read concurrent with link rise
        cur_req = "R11";
        @(negedge clk);
        link_up = 1'b1; frame_we = 1'b1; frame_wdata = frame(1'b1, MY_PHY, 29, 16'h0);
        @(negedge clk); frame_we = 1'b0;
        chk("R11 read returns down bit", {16'h0, frame_rdata[15:0]}, 32'h0010);
        rd_chk("R11 concurrent event kept", MY_PHY, 29, 16'h00C0);

        // R12 soft reset with link up
        cur_req = "R12";
        op(frame(1'b0, MY_PHY, 0, 16'h8000));
        rd_chk("R12 control restored", MY_PHY, 0, 16'h3000);
        rd_chk("R12 adv restored", MY_PHY, 4, 16'h01E1);
        rd_chk("R12 mask restored", MY_PHY, 30, 16'h0000);
        rd_chk("R12 status relinked", MY_PHY, 1, 16'h782D);
        rd_chk("R12 isrc relinked", MY_PHY, 29, 16'h00C0);

        // R13 fixed and unimplemented registers
        cur_req = "R13";
        rd_chk("R13 partner ability", MY_PHY, 5, 16'h05E1);
        rd_chk("R13 expansion", MY_PHY, 6, 16'h0001);
        rd_chk("R13 unimpl reg2", MY_PHY, 2, 16'h0000);
        rd_chk("R13 unimpl reg31", MY_PHY, 31, 16'h0000);
        op(frame(1'b0, MY_PHY, 1, 16'h0000));
        rd_chk("R13 status write ignored", MY_PHY, 1, 16'h782D);
        op(frame(1'b0, MY_PHY, 29, 16'h00FF));
        rd_chk("R13 isrc write ignored", MY_PHY, 29, 16'h0000);

        idle(2);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule